// File: doc/BRIEF.md
# Funnel-Shift Field Extract/Insert Unit

This block is the bit-field engine of a 32-bit execution datapath. It receives two operand words and a 16-bit field descriptor. It joins the left and right operands into one double word and shifts that double word left by the descriptor's shift count. It then keeps only the lowest "mask width" bits of the upper word. In insert mode, bits of the right operand are merged back around the extracted field. The result is ready in the same cycle.

The descriptor comes from one of two places. The first is a held descriptor register, which a load strobe writes from a late-stage result word. The second is the low half of an immediate word. A select input chooses between them for each operation. A descriptor whose shift count or mask width is above 32 is illegal. Such a descriptor raises an error flag and forces the result to zero.

Top module: `fu_field_unit`

## Requirements
- R1: Only descriptor bits 15:0 are used. Bit 15 is the insert flag, bits 13:8 are the mask width m and bits 5:0 are the shift count s. Bits 31:16, bit 14 and bits 7:6 have no effect on `result` or `desc_err`.
- R2: With s = 0, the shifted word equals `left_op`. For example, m = 32 in extract mode gives `result == left_op`.
- R3: With s = 32, the shifted word equals `right_op`. For example, m = 32 in extract mode gives `result == right_op`.
- R4: With s from 1 to 31, the shifted word is `left_op` shifted left by s, with the top s bits of `right_op` filling its low s bits.
- R5: In extract mode (insert flag 0), `result` is the shifted word ANDed with a mask of m low ones. Every bit at position m or above is zero, and m = 0 gives zero.
- R6: In insert mode (insert flag 1), `result` is the extract result ORed with `right_op` ANDed with the inverse of ((m low ones) XOR (s low ones)).
- R7: When `use_imm` = 1, the descriptor is `imm_word[15:0]`. When `use_imm` = 0, the descriptor is the held register.
- R8: The held register resets to 0. It captures `load_word[15:0]` on a rising clock edge when `load_desc` = 1, and the new value is used from the next cycle on. It keeps its value when `load_desc` = 0.
- R9: If s > 32 or m > 32, `desc_err` = 1 and `result` = 0. Otherwise `desc_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the descriptor register |
| rst_n | input | 1 | Active-low asynchronous reset |
| left_op | input | 32 | Upper half of the funnel pair |
| right_op | input | 32 | Lower half of the funnel pair and the insert background |
| imm_word | input | 32 | Immediate descriptor source (low 16 bits used) |
| use_imm | input | 1 | 1 selects the immediate descriptor, 0 selects the held register |
| load_desc | input | 1 | Strobe that writes the held descriptor register |
| load_word | input | 32 | Data written to the held register (low 16 bits kept) |
| result | output | 32 | Extract or insert result |
| desc_err | output | 1 | Selected descriptor has a count above 32 |

## Verification
The only state in the block is the held descriptor register. If that register is corrupted or misloaded, nothing shows while `use_imm` is 1. The fault appears on `result` and `desc_err` in the first cycle that selects the register after the bad edge. The bench therefore reads the register back through `use_imm` = 0 right after each load and after cycles where the strobe is low and `load_word` is changing. A fault in the shift, mask or merge logic is purely combinational. It shows in the same cycle, but only for descriptors whose counts reach the faulty bit positions, so the stimulus covers the counts 0, 32, middle values and out-of-range values.

// File: rtl/fu_pkg.sv
package fu_pkg;
  localparam int FU_INS_BIT  = 15;
  localparam int FU_MASK_LO  = 8;
  localparam int FU_SHIFT_LO = 0;
  localparam int FU_CNT_W    = 6;

  typedef struct packed {
    logic                insert;
    logic [FU_CNT_W-1:0] mwid;
    logic [FU_CNT_W-1:0] shamt;
  } fu_desc_t;
endpackage

// File: rtl/fu_desc_store.sv
module fu_desc_store #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  output logic [DW-1:0] desc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      desc_q <= '0;
    else if (load)
      desc_q <= load_word;
  end
endmodule

// File: rtl/fu_desc_pick.sv
module fu_desc_pick
  import fu_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic          use_imm,
  input  logic [DW-1:0] desc_q,
  input  logic [DW-1:0] imm_desc,
  output fu_desc_t      desc,
  output logic          bad
);
  logic [DW-1:0] chosen;

  function automatic fu_desc_t unpack_desc(input logic [DW-1:0] raw);
    fu_desc_t d;
    d.insert = raw[FU_INS_BIT];
    d.mwid   = raw[FU_MASK_LO +: FU_CNT_W];
    d.shamt  = raw[FU_SHIFT_LO +: FU_CNT_W];
    return d;
  endfunction

  always_comb begin
    chosen = use_imm ? imm_desc : desc_q;
    desc   = unpack_desc(chosen);
    bad    = (desc.shamt > FU_CNT_W'(W)) || (desc.mwid > FU_CNT_W'(W));
  end
endmodule

// File: rtl/fu_funnel.sv
module fu_funnel #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  left_op,
  input  logic [W-1:0]  right_op,
  input  logic [CW-1:0] shamt,
  output logic [W-1:0]  shifted
);
  function automatic logic [W-1:0] funnel_left(input logic [W-1:0] hi,
                                               input logic [W-1:0] lo,
                                               input logic [CW-1:0] n);
    logic [2*W-1:0] pair;
    pair = {hi, lo} << n;
    return pair[2*W-1:W];
  endfunction

  assign shifted = funnel_left(left_op, right_op, shamt);
endmodule

// File: rtl/fu_merge.sv
module fu_merge #(
  parameter int W  = 32,
  parameter int CW = 6
) (
  input  logic [W-1:0]  shifted,
  input  logic [W-1:0]  right_op,
  input  logic          insert,
  input  logic [CW-1:0] mwid,
  input  logic [CW-1:0] shamt,
  input  logic          bad,
  output logic [W-1:0]  field_mask,
  output logic [W-1:0]  keep_mask,
  output logic [W-1:0]  result
);
  logic [W-1:0] shift_mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign field_mask[i] = mwid  > CW'(i);
    assign shift_mask[i] = shamt > CW'(i);
  end

  assign keep_mask = ~(field_mask ^ shift_mask);

  always_comb begin
    result = shifted & field_mask;
    if (insert)
      result = result | (right_op & keep_mask);
    if (bad)
      result = '0;
  end
endmodule

// File: rtl/fu_field_unit.sv
module fu_field_unit
  import fu_pkg::*;
#(
  parameter int W  = 32,
  parameter int DW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] left_op,
  input  logic [W-1:0] right_op,
  input  logic [W-1:0] imm_word,
  input  logic         use_imm,
  input  logic         load_desc,
  input  logic [W-1:0] load_word,
  output logic [W-1:0] result,
  output logic         desc_err
);
  localparam int CW = FU_CNT_W;

  logic [DW-1:0] desc_q;
  fu_desc_t      desc;
  logic          bad;
  logic [W-1:0]  shifted;
  logic [W-1:0]  field_mask;
  logic [W-1:0]  keep_mask;

  fu_desc_store #(.DW(DW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_desc),
    .load_word(load_word[DW-1:0]),
    .desc_q   (desc_q)
  );

  fu_desc_pick #(.W(W), .DW(DW)) u_pick (
    .use_imm (use_imm),
    .desc_q  (desc_q),
    .imm_desc(imm_word[DW-1:0]),
    .desc    (desc),
    .bad     (bad)
  );

  fu_funnel #(.W(W), .CW(CW)) u_funnel (
    .left_op (left_op),
    .right_op(right_op),
    .shamt   (desc.shamt),
    .shifted (shifted)
  );

  fu_merge #(.W(W), .CW(CW)) u_merge (
    .shifted   (shifted),
    .right_op  (right_op),
    .insert    (desc.insert),
    .mwid      (desc.mwid),
    .shamt     (desc.shamt),
    .bad       (bad),
    .field_mask(field_mask),
    .keep_mask (keep_mask),
    .result    (result)
  );

  assign desc_err = bad;
endmodule

// File: rtl/fu_field_unit_chk.sv
module fu_field_unit_chk #(
  parameter int W  = 32,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  left_op,
  input logic [W-1:0]  right_op,
  input logic          load_desc,
  input logic [W-1:0]  load_word,
  input logic [DW-1:0] desc_q,
  input logic          insert,
  input logic [CW-1:0] mwid,
  input logic [CW-1:0] shamt,
  input logic [W-1:0]  field_mask,
  input logic [W-1:0]  result,
  input logic          desc_err
);
  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> result == '0);

  // R5
  field_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_err && !insert) |-> (result & ~field_mask) == '0);

  // R2
  pass_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_err && !insert && shamt == '0 && mwid == CW'(W)) |-> result == left_op);

  // R3
  pass_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_err && !insert && shamt == CW'(W) && mwid == CW'(W)) |-> result == right_op);

  // R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_desc |=> desc_q == $past(load_word[DW-1:0]));

  // R8
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_desc |=> $stable(desc_q));
endmodule

bind fu_field_unit fu_field_unit_chk #(.W(W), .DW(DW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .left_op   (left_op),
  .right_op  (right_op),
  .load_desc (load_desc),
  .load_word (load_word),
  .desc_q    (desc_q),
  .insert    (desc.insert),
  .mwid      (desc.mwid),
  .shamt     (desc.shamt),
  .field_mask(field_mask),
  .result    (result),
  .desc_err  (desc_err)
);

// File: tb/tb_fu_field_unit.sv
`timescale 1ns/1ps
module tb_fu_field_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] left_op = '0, right_op = '0, imm_word = '0, load_word = '0;
  logic        use_imm = 1'b0, load_desc = 1'b0;
  logic [31:0] result;
  logic        desc_err;

  always #2.5 clk = ~clk;

  fu_field_unit dut (
    .clk(clk), .rst_n(rst_n), .left_op(left_op), .right_op(right_op),
    .imm_word(imm_word), .use_imm(use_imm), .load_desc(load_desc),
    .load_word(load_word), .result(result), .desc_err(desc_err)
  );

  typedef struct {
    logic [31:0] res;
    logic        err;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    total = 0, bad = 0;
  bit    done = 1'b0;
  logic [15:0] model_desc = 16'h0;

  function automatic logic [31:0] mk(input bit ins, input int m, input int s);
    logic [31:0] w;
    w = '0;
    w[15] = ins;
    w[13:8] = m[5:0];
    w[5:0] = s[5:0];
    return w;
  endfunction

  // Bit-by-bit restatement of R2..R6 and R9
  function automatic exp_t model(input logic [15:0] d, input logic [31:0] l,
                                 input logic [31:0] r, input string tag);
    exp_t e;
    int s, m;
    s = int'(d[5:0]);
    m = int'(d[13:8]);
    e.tag = tag;
    e.res = '0;
    e.err = (s > 32) || (m > 32);
    if (!e.err) begin
      for (int i = 0; i < 32; i++) begin
        logic sb_bit;
        sb_bit = (i >= s) ? l[i - s] : r[32 + i - s];
        if (i < m) e.res[i] = sb_bit;
        if (d[15] && !((i < m) ^ (i < s))) e.res[i] = e.res[i] | r[i];
      end
    end
    return e;
  endfunction

  task automatic apply(input string tag, input logic [31:0] l, input logic [31:0] r,
                       input logic [31:0] imm, input bit sel);
    @(posedge clk); #1;
    left_op = l; right_op = r; imm_word = imm; use_imm = sel;
    load_desc = 1'b0; load_word = ~imm ^ 32'h1357_9BDF;
    sb.push_back(model(sel ? imm[15:0] : model_desc, l, r, tag));
  endtask

  task automatic load(input logic [31:0] v);
    @(posedge clk); #1;
    load_desc = 1'b1; load_word = v;
    @(posedge clk); #1;
    load_desc = 1'b0;
    model_desc = v[15:0];
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (result !== e.res || desc_err !== e.err) begin
        bad++;
        $display("FAIL %s: result=%h err=%b expected result=%h err=%b",
                 e.tag, result, desc_err, e.res, e.err);
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    a = 32'hDEAD_BEEF;
    b = 32'h0123_4567;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    apply("R8 reset register is zero", a, b, mk(1, 32, 32), 1'b0);
    apply("R2 shift 0 passes left", a, b, mk(0, 32, 0), 1'b1);
    apply("R3 shift 32 passes right", a, b, mk(0, 32, 32), 1'b1);
    apply("R4 shift 1", a, b, mk(0, 32, 1), 1'b1);
    apply("R4 shift 8", a, b, mk(0, 32, 8), 1'b1);
    apply("R4 shift 31", a, b, mk(0, 32, 31), 1'b1);
    apply("R5 mask 0 gives zero", a, b, mk(0, 0, 4), 1'b1);
    apply("R5 mask 12 shift 20", a, b, mk(0, 12, 20), 1'b1);
    apply("R6 insert m16 s8", a, b, mk(1, 16, 8), 1'b1);
    apply("R6 insert m8 s20", 32'hFFFF_0000, 32'h00FF_00FF, mk(1, 8, 20), 1'b1);
    apply("R6 insert m32 s32", a, b, mk(1, 32, 32), 1'b1);
    apply("R1 ignored descriptor bits", a, b, mk(0, 24, 12) | 32'hABCD_40C0, 1'b1);
    apply("R1 ignored bits with insert", b, a, mk(1, 20, 3) | 32'h7F00_40C0, 1'b1);
    load(mk(1, 20, 4) | 32'hFFFF_0000);
    apply("R8 loaded register used", a, b, 32'h0, 1'b0);
    apply("R7 immediate overrides register", a, b, mk(0, 8, 0), 1'b1);
    apply("R8 register held without strobe", b, a, 32'h0000_2020, 1'b0);
    apply("R7 register path again", a, b, mk(0, 40, 0), 1'b0);
    load(mk(0, 33, 0));
    apply("R9 register mask 33", a, b, 32'h0, 1'b0);
    apply("R9 shift 40", a, b, mk(0, 5, 40), 1'b1);
    apply("R9 both 63 insert", a, b, mk(1, 63, 63), 1'b1);
    apply("R9 limits 32 legal", a, b, mk(1, 32, 0), 1'b1);
    for (int k = 0; k < 24; k++) begin
      a = a * 32'd1103515245 + 32'd12345;
      b = {b[30:0], b[31] ^ b[21] ^ b[1] ^ b[0]} ^ a;
      apply("R4 R5 R6 sweep", a, b, mk(k[0], (k * 7) % 33, (k * 11) % 33), 1'b1);
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule